// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block buffers 9-bit words between two unrelated clock domains. Words enter on the write clock and leave on the read clock. The storage depth is a power of two set by a parameter. Each side keeps a binary pointer and a gray-coded pointer that is one bit wider than the address. Each gray pointer passes to the other domain through a chain of synchroniser flops. Because the copy in the other domain lags, the empty and full indications clear late and never early.

The output behaviour is picked while master reset is held. In standard timing, the read status pin is an active-low empty indication and the write status pin is an active-low full indication. A word reaches the data output only on an explicit read. In fall-through timing, the read status pin goes low when a valid word is at the output and the write status pin goes low when there is room. The oldest stored word moves to the output without any read request.

Partial reset empties the buffer but keeps the chosen timing. Retransmit rewinds the read side to the first word written since the last reset, so a stored frame can be read again. Retransmit is to be issued while writes are idle and while no more than the depth in words has been written since reset. An active-low half-full indication reports the write side's view of occupancy.

Top module: `dual_clock_fifo`

## Requirements
- R1: The timing mode is captured on every read-clock edge while `mrst_n` is low: `fwft_sel`=1 selects fall-through timing and 0 selects standard timing. While `mrst_n` is high the mode does not change.
- R2: Partial reset (`prst_n` low) discards every stored word and clears `dout` to 0. It keeps the captured mode and does not sample `fwft_sel`.
- R3: After either reset, `dout`=0 and `half_full_n`=1. In standard timing `rd_status`=0 and `wr_status`=1. In fall-through timing `rd_status`=1 and `wr_status`=0.
- R4: A word is stored on a write-clock edge where `wr_en_n` is low and the buffer is not full. Writes while full are dropped, and the stored words stay as they were.
- R5: When the write side sees DEPTH unread words (16 by default), `wr_status` is 0 in standard timing and 1 in fall-through timing.
- R6: In standard timing, `dout` takes the next word, in write order, only on a read-clock edge where `rd_en_n` is low and the buffer is not empty. Otherwise it holds its value. `rd_status` is 0 whenever no unread word is left.
- R7: In fall-through timing, a word written into an empty buffer appears on `dout` with `rd_status` low at the third read-clock edge after the write edge (SYNC_STAGES+1). No read request is needed.
- R8: In fall-through timing, `rd_status` stays low while the last word is held. A read with a further word stored presents that word on the same edge. A read with nothing further stored raises `rd_status` on that edge.
- R9: `half_full_n` is 0 when the words written minus the synchronised words read exceed DEPTH/2, and 1 otherwise.
- R10: A read-clock edge with `retx_n` low rewinds reading to the first word written since the last reset. Later reads repeat the stream from that word.
- R11: When retransmit and a read fall on the same read-clock edge, the retransmit wins and the read is not performed. In standard timing `dout` holds through that edge.
- R12: In fall-through timing, `rd_status` is 1 after the retransmit edge. On the next read-clock edge the first word is presented again with `rd_status` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion; mode captured while low |
| prst_n | input | 1 | Partial reset, active low, asynchronous assertion; mode kept |
| fwft_sel | input | 1 | Timing choice sampled during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write request, active low |
| din | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| retx_n | input | 1 | Retransmit request, active low, read-clock domain |
| dout | output | DATA_W | Output word register |
| rd_status | output | 1 | Standard: 0 = empty; fall-through: 0 = valid word on dout |
| wr_status | output | 1 | Standard: 0 = full; fall-through: 0 = room available |
| half_full_n | output | 1 | 0 when more than half the depth is occupied |

## Verification
Retransmit and read both act on the read pointer, so they can land on the same read-clock edge. The bench provokes this by driving `retx_n` and `rd_en_n` low together for one read cycle, after part of a stored stream has been read. The outcome is judged at the ports: `dout` must hold the word it showed before that edge, and the next plain read must return the first word written. In fall-through timing, the retransmit edge must raise `rd_status` for exactly one cycle before the first word reappears.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   // Output timing selected at master reset
   typedef enum logic {
      TM_STANDARD = 1'b0,
      TM_FALLTHRU = 1'b1
   } tmode_e;

   // Minimum legal synchroniser length
   localparam int unsigned MIN_SYNC = 2;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 4
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int unsigned WORDS = 1 << AW;

   logic [DW-1:0] cells [WORDS];

   always_ff @(posedge wr_clk) begin
      if (we) cells[waddr] <= wdata;
   end

   // Read register lives in the read controller
   assign rdata = cells[raddr];

endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [AW:0]   rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wbin,
   output logic [AW:0]   wgray,
   output logic          full,
   output logic          half
);

   localparam int unsigned PW        = AW + 1;
   localparam int unsigned DEPTH     = 1 << AW;
   localparam logic [AW:0] HALF_MARK = PW'(DEPTH / 2);

   logic [AW:0] bin_nx;
   logic [AW:0] gray_nx;
   logic [AW:0] rbin_s;
   logic [AW:0] occ;

   // Full: read pointer one lap behind (top two gray bits inverted)
   assign full   = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
   assign we     = wr_req & ~full;
   assign waddr  = wbin[AW-1:0];
   assign bin_nx = wbin + 1'b1;
   assign gray_nx = bin_nx ^ (bin_nx >> 1);

   always_comb begin
      for (int i = 0; i < int'(PW); i++) rbin_s[i] = ^(rgray_s >> i);
   end

   assign occ  = wbin - rbin_s;
   assign half = (occ > HALF_MARK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (we) begin
         wbin  <= bin_nx;
         wgray <= gray_nx;
      end
   end

endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
   import dcf_pkg::*;
#(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  tmode_e        mode,
   input  logic          rd_req,
   input  logic          retx_req,
   input  logic [AW:0]   wgray_s,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rbin,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          empty,
   output logic          valid
);

   logic [AW:0] bin_nx;
   logic [AW:0] gray_nx;
   logic        load;
   logic        drain;

   assign empty   = (rgray == wgray_s);
   assign raddr   = rbin[AW-1:0];
   assign bin_nx  = rbin + 1'b1;
   assign gray_nx = bin_nx ^ (bin_nx >> 1);

   always_comb begin
      unique case (mode)
         TM_FALLTHRU: load = ~empty & (~valid | rd_req);
         default:     load = rd_req & ~empty;
      endcase
   end

   // Fall-through read with nothing left behind the held word
   assign drain = (mode == TM_FALLTHRU) & valid & rd_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
         dout  <= '0;
         valid <= 1'b0;
      end else if (retx_req) begin
         rbin  <= '0;
         rgray <= '0;
         valid <= 1'b0;
      end else if (load) begin
         dout  <= rdata;
         rbin  <= bin_nx;
         rgray <= gray_nx;
         valid <= 1'b1;
      end else if (drain) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
   import dcf_pkg::*;
#(
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic              wr_en_n,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_en_n,
   input  logic              retx_n,
   output logic [DATA_W-1:0] dout,
   output logic              rd_status,
   output logic              wr_status,
   output logic              half_full_n
);

   localparam int unsigned PTR_W = ADDR_W + 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dual_clock_fifo: ADDR_W must be 2 or more");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("dual_clock_fifo: SYNC_STAGES below minimum");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dual_clock_fifo: DATA_W must be positive");
      end
   endgenerate

   logic              arst_n;
   tmode_e            mode_q;
   logic              fwft_q;
   logic              we;
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] raddr;
   logic [DATA_W-1:0] rdata;
   logic [PTR_W-1:0]  wbin;
   logic [PTR_W-1:0]  wgray;
   logic [PTR_W-1:0]  rbin;
   logic [PTR_W-1:0]  rgray;
   logic [PTR_W-1:0]  wgray_s;
   logic [PTR_W-1:0]  rgray_s;
   logic              wfull;
   logic              whalf;
   logic              rempty;
   logic              ovalid;

   assign arst_n = mrst_n & prst_n;

   // Mode capture: only while master reset is held
   always_ff @(posedge rd_clk) begin
      if (!mrst_n) mode_q <= fwft_sel ? TM_FALLTHRU : TM_STANDARD;
   end
   assign fwft_q = (mode_q == TM_FALLTHRU);

   dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
      .wr_clk (wr_clk),
      .we     (we),
      .waddr  (waddr),
      .wdata  (din),
      .raddr  (raddr),
      .rdata  (rdata)
   );

   dcf_wr_ctrl #(.AW(ADDR_W)) u_wr (
      .clk     (wr_clk),
      .rst_n   (arst_n),
      .wr_req  (~wr_en_n),
      .rgray_s (rgray_s),
      .we      (we),
      .waddr   (waddr),
      .wbin    (wbin),
      .wgray   (wgray),
      .full    (wfull),
      .half    (whalf)
   );

   dcf_rd_ctrl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
      .clk      (rd_clk),
      .rst_n    (arst_n),
      .mode     (mode_q),
      .rd_req   (~rd_en_n),
      .retx_req (~retx_n),
      .wgray_s  (wgray_s),
      .rdata    (rdata),
      .raddr    (raddr),
      .rbin     (rbin),
      .rgray    (rgray),
      .dout     (dout),
      .empty    (rempty),
      .valid    (ovalid)
   );

   dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk   (rd_clk),
      .rst_n (arst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk   (wr_clk),
      .rst_n (arst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   assign rd_status   = fwft_q ? ~ovalid : ~rempty;
   assign wr_status   = fwft_q ? wfull   : ~wfull;
   assign half_full_n = ~whalf;

endmodule

// File: rtl/dual_clock_fifo_chk.sv
module dual_clock_fifo_chk #(
   parameter int unsigned PW = 5,
   parameter int unsigned DW = 9
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          mrst_n,
   input logic          arst_n,
   input logic          fwft_q,
   input logic          wr_en_n,
   input logic          rd_en_n,
   input logic          retx_n,
   input logic          wfull,
   input logic [PW-1:0] wbin,
   input logic          rempty,
   input logic          ovalid,
   input logic [PW-1:0] rbin,
   input logic [DW-1:0] dout,
   input logic          half_full_n
);

   // R4: a write attempt while full leaves the write pointer unchanged
   p_no_overflow_r4: assert property (@(posedge wr_clk) disable iff (!arst_n)
      (wfull && !wr_en_n) |=> $stable(wbin));

   // R9: a full buffer is always reported as more than half full
   p_half_when_full_r9: assert property (@(posedge wr_clk) disable iff (!arst_n)
      wfull |-> !half_full_n);

   // R6: standard output register holds without a read that can be served
   p_std_hold_r6: assert property (@(posedge rd_clk) disable iff (!arst_n)
      (!fwft_q && (rd_en_n || rempty)) |=> $stable(dout));

   // R8: fall-through held word stays valid and unchanged without a read
   p_ft_keep_r8: assert property (@(posedge rd_clk) disable iff (!arst_n)
      (fwft_q && ovalid && rd_en_n && retx_n) |=> (ovalid && $stable(dout)));

   // R10: retransmit rewinds the read pointer to the first location
   p_retx_rewind_r10: assert property (@(posedge rd_clk) disable iff (!arst_n)
      !retx_n |=> (rbin == '0));

   // R1: mode is frozen once master reset is released
   p_mode_hold_r1: assert property (@(posedge rd_clk) disable iff (!mrst_n)
      mrst_n |=> $stable(fwft_q));

endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.PW(ADDR_W + 1), .DW(DATA_W)) u_chk (
   .wr_clk      (wr_clk),
   .rd_clk      (rd_clk),
   .mrst_n      (mrst_n),
   .arst_n      (arst_n),
   .fwft_q      (fwft_q),
   .wr_en_n     (wr_en_n),
   .rd_en_n     (rd_en_n),
   .retx_n      (retx_n),
   .wfull       (wfull),
   .wbin        (wbin),
   .rempty      (rempty),
   .ovalid      (ovalid),
   .rbin        (rbin),
   .dout        (dout),
   .half_full_n (half_full_n)
);

// File: tb/dual_clock_fifo_tb_top.sv
module dual_clock_fifo_tb_top;

   localparam int WR_PERIOD = 10;
   localparam int RD_PERIOD = 14;
   localparam int DEPTH     = 16;
   localparam int WATCHDOG  = 100000 * WR_PERIOD;

   logic       wr_clk = 1'b0;
   logic       rd_clk = 1'b0;
   logic       mrst_n = 1'b0;
   logic       prst_n = 1'b1;
   logic       fwft_sel = 1'b0;
   logic       wr_en_n = 1'b1;
   logic [8:0] din = '0;
   logic       rd_en_n = 1'b1;
   logic       retx_n = 1'b1;
   logic [8:0] dout;
   logic       rd_status;
   logic       wr_status;
   logic       half_full_n;

   int n_vec = 0;
   int n_bad = 0;

   dual_clock_fifo dut_i (
      .wr_clk      (wr_clk),
      .rd_clk      (rd_clk),
      .mrst_n      (mrst_n),
      .prst_n      (prst_n),
      .fwft_sel    (fwft_sel),
      .wr_en_n     (wr_en_n),
      .din         (din),
      .rd_en_n     (rd_en_n),
      .retx_n      (retx_n),
      .dout        (dout),
      .rd_status   (rd_status),
      .wr_status   (wr_status),
      .half_full_n (half_full_n)
   );

   initial forever #(WR_PERIOD / 2) wr_clk = ~wr_clk;
   initial begin
      #1;
      forever #(RD_PERIOD / 2) rd_clk = ~rd_clk;
   end

   task automatic expect_eq(input string tag, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle_rd(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   task automatic master_reset(input logic ft);
      wr_en_n = 1'b1; rd_en_n = 1'b1; retx_n = 1'b1;
      fwft_sel = ft;
      mrst_n = 1'b0;
      repeat (3) @(posedge rd_clk);
      repeat (2) @(posedge wr_clk);
      @(negedge rd_clk);
      #3 mrst_n = 1'b1;
      fwft_sel = ~ft;
      idle_rd(2);
   endtask

   task automatic partial_reset();
      prst_n = 1'b0;
      repeat (3) @(posedge rd_clk);
      repeat (2) @(posedge wr_clk);
      @(negedge rd_clk);
      #3 prst_n = 1'b1;
      idle_rd(2);
   endtask

   task automatic wr_word(input logic [8:0] d);
      @(negedge wr_clk);
      din = d; wr_en_n = 1'b0;
      @(negedge wr_clk);
      wr_en_n = 1'b1;
   endtask

   task automatic rd_word();
      @(negedge rd_clk);
      rd_en_n = 1'b0;
      @(negedge rd_clk);
      rd_en_n = 1'b1;
   endtask

   task automatic t_reset_standard();
      master_reset(1'b0);
      expect_eq("R3 std rd_status", int'(rd_status), 0);
      expect_eq("R3 std wr_status", int'(wr_status), 1);
      expect_eq("R3 half_full_n", int'(half_full_n), 1);
      expect_eq("R3 dout", int'(dout), 0);
   endtask

   task automatic t_standard_order();
      master_reset(1'b0);
      wr_word(9'h0A5); wr_word(9'h15A); wr_word(9'h1FF);
      idle_rd(6);
      expect_eq("R6 not empty", int'(rd_status), 1);
      expect_eq("R6 no read no data", int'(dout), 0);
      rd_word();
      expect_eq("R6 first word", int'(dout), 'h0A5);
      idle_rd(3);
      expect_eq("R6 hold", int'(dout), 'h0A5);
      rd_word();
      expect_eq("R6 second word", int'(dout), 'h15A);
      rd_word();
      expect_eq("R6 third word", int'(dout), 'h1FF);
      expect_eq("R6 empty after last", int'(rd_status), 0);
      rd_word();
      expect_eq("R6 read on empty holds", int'(dout), 'h1FF);
   endtask

   task automatic t_fill_and_overflow();
      master_reset(1'b0);
      for (int i = 0; i < DEPTH; i++) begin
         wr_word(9'(9'h100 + i));
         if (i == DEPTH / 2 - 1) expect_eq("R9 at half", int'(half_full_n), 1);
         if (i == DEPTH / 2)     expect_eq("R9 above half", int'(half_full_n), 0);
      end
      expect_eq("R5 std full", int'(wr_status), 0);
      wr_word(9'h1F0); wr_word(9'h1F1);
      expect_eq("R5 still full", int'(wr_status), 0);
      idle_rd(6);
      for (int i = 0; i < DEPTH; i++) begin
         rd_word();
         expect_eq("R4 stored word", int'(dout), 'h100 + i);
      end
      expect_eq("R4 dropped writes absent", int'(rd_status), 0);
      repeat (6) @(negedge wr_clk);
      expect_eq("R5 full clears", int'(wr_status), 1);
      expect_eq("R9 half clears", int'(half_full_n), 1);
   endtask

   task automatic t_ft_latency();
      master_reset(1'b1);
      expect_eq("R3 ft rd_status", int'(rd_status), 1);
      expect_eq("R3 ft wr_status", int'(wr_status), 0);
      expect_eq("R1 ft mode dout", int'(dout), 0);
      @(negedge wr_clk);
      din = 9'h0C3; wr_en_n = 1'b0;
      @(posedge wr_clk);
      fork
         begin @(negedge wr_clk); wr_en_n = 1'b1; end
      join_none
      @(posedge rd_clk);
      @(posedge rd_clk);
      #1 expect_eq("R7 not yet at edge 2", int'(rd_status), 1);
      @(posedge rd_clk);
      #1 expect_eq("R7 ready at edge 3", int'(rd_status), 0);
      expect_eq("R7 word at edge 3", int'(dout), 'h0C3);
   endtask

   task automatic t_ft_last_word();
      idle_rd(4);
      expect_eq("R8 held last word", int'(rd_status), 0);
      wr_word(9'h111); wr_word(9'h122);
      idle_rd(6);
      expect_eq("R8 no read keeps head", int'(dout), 'h0C3);
      rd_word();
      expect_eq("R8 next word", int'(dout), 'h111);
      rd_word();
      expect_eq("R8 last word", int'(dout), 'h122);
      expect_eq("R8 last word valid", int'(rd_status), 0);
      idle_rd(4);
      expect_eq("R8 stays valid", int'(rd_status), 0);
      rd_word();
      expect_eq("R8 read past end", int'(rd_status), 1);
   endtask

   task automatic t_retx_standard();
      master_reset(1'b0);
      for (int i = 0; i < 4; i++) wr_word(9'(9'h0A0 + i));
      idle_rd(6);
      rd_word();
      rd_word();
      expect_eq("R6 before retx", int'(dout), 'h0A1);
      @(negedge rd_clk);
      rd_en_n = 1'b0; retx_n = 1'b0;
      @(negedge rd_clk);
      rd_en_n = 1'b1; retx_n = 1'b1;
      expect_eq("R11 read lost to retx", int'(dout), 'h0A1);
      rd_word();
      expect_eq("R10 replay first", int'(dout), 'h0A0);
      rd_word();
      expect_eq("R10 replay second", int'(dout), 'h0A1);
      rd_word();
      expect_eq("R10 replay third", int'(dout), 'h0A2);
   endtask

   task automatic t_retx_fallthru();
      master_reset(1'b1);
      wr_word(9'h050); wr_word(9'h051); wr_word(9'h052);
      idle_rd(6);
      expect_eq("R7 head", int'(dout), 'h050);
      rd_word();
      expect_eq("R8 advance", int'(dout), 'h051);
      @(negedge rd_clk);
      retx_n = 1'b0;
      @(posedge rd_clk);
      #1 expect_eq("R12 not ready in setup", int'(rd_status), 1);
      retx_n = 1'b1;
      @(posedge rd_clk);
      #1 expect_eq("R12 ready again", int'(rd_status), 0);
      expect_eq("R12 first word again", int'(dout), 'h050);
   endtask

   task automatic t_partial_reset();
      fwft_sel = 1'b0;
      partial_reset();
      expect_eq("R2 ft kept rd_status", int'(rd_status), 1);
      expect_eq("R2 ft kept wr_status", int'(wr_status), 0);
      expect_eq("R2 dout cleared", int'(dout), 0);
      wr_word(9'h0EE);
      idle_rd(6);
      expect_eq("R2 old words gone", int'(dout), 'h0EE);
      expect_eq("R2 falls through", int'(rd_status), 0);
   endtask

   task automatic t_back_to_standard();
      master_reset(1'b0);
      expect_eq("R1 std rd_status", int'(rd_status), 0);
      expect_eq("R1 std wr_status", int'(wr_status), 1);
      wr_word(9'h033);
      idle_rd(6);
      expect_eq("R1 no fall-through", int'(dout), 0);
   endtask

   task automatic run_all();
      t_reset_standard();
      t_standard_order();
      t_fill_and_overflow();
      t_ft_latency();
      t_ft_last_word();
      t_retx_standard();
      t_retx_fallthru();
      t_partial_reset();
      t_back_to_standard();
   endtask

   initial begin
      fork
         run_all();
         begin
            #(WATCHDOG);
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule